// File: doc/BRIEF.md
# Input Port Event Wait Unit

This unit carries out the wait-for-event instruction of a small 4-bit processor. When the decoder issues the instruction, the unit looks at one of several 4-bit input ports, chosen by the instruction operand. It combines that port's value with the accumulator using one of three modes: the raw port value, the port masked by the accumulator (AND), or the change against the accumulator (XOR). While the combined value is zero the unit asks the core to stall, which freezes the program counter. It samples the port again on every clock cycle.

When the combined value becomes nonzero, the unit releases the stall in that same cycle. It then issues one-cycle write strobes: the combined value goes into the accumulator, the raw port value goes into the second register B, and the zero flag is cleared. The input ports are asynchronous to the core, so every port bit passes through a two-stage synchroniser before it is used. The mode, port number and accumulator operand are captured when the instruction starts, and they stay fixed until release.

Top module: `evt_wait_unit`

## Requirements
- R1: While reset is active and after reset is released with no instruction issued, `stall_o`, `acc_we_o`, `b_we_o` and `zf_clr_o` are all low.
- R2: From the cycle `start_i` is high until the release cycle, `stall_o` is high whenever the combined value is zero, and no write strobe is raised. The stall holds after `start_i` returns low.
- R3: If the combined value is already nonzero in the cycle `start_i` is high, `stall_o` stays low and the release strobes appear in that same cycle.
- R4: Mode 2'b00 (raw): the combined value is the synchronised port value.
- R5: Mode 2'b01 (masked): the combined value is the port AND the accumulator value present on `acc_i` in the start cycle. Changes on `acc_i` after the start cycle have no effect.
- R6: Mode 2'b10 (change): the combined value is the port XOR the captured accumulator, so a bit changing in either direction releases the wait.
- R7: In the release cycle `acc_we_o`, `b_we_o` and `zf_clr_o` are high for one cycle, with `acc_wdata_o` equal to the combined value and `b_wdata_o` equal to the raw synchronised port value. In the next cycle they are low, unless a new instruction starts.
- R8: Port n occupies bits [4n+3:4n] of `port_i`. Only the port selected by `sel_i` in the start cycle can release the wait; activity on other ports has no effect.
- R9: A change on `port_i` reaches the combine logic after exactly two rising clock edges, so release happens in the cycle after the second edge.
- R10: Mode 2'b11 behaves exactly like raw mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse issuing the wait instruction |
| mode_i | input | 2 | Combine mode: 00 raw, 01 AND, 10 XOR, 11 raw |
| sel_i | input | 4 | Port number from the instruction operand |
| port_i | input | 64 | All input ports, 4 bits each, asynchronous |
| acc_i | input | 4 | Current accumulator value |
| stall_o | output | 1 | Hold the program counter and the instruction |
| acc_we_o | output | 1 | Accumulator write strobe on release |
| acc_wdata_o | output | 4 | Value to write into the accumulator |
| b_we_o | output | 1 | Register B write strobe on release |
| b_wdata_o | output | 4 | Raw port value to write into register B |
| zf_clr_o | output | 1 | Clear the zero flag on release |

## Verification
The hardest case to reach is a wait that is already stalled and must then release. The release has to happen exactly two edges after a port change and must use the operands captured at the start. The bench issues a one-cycle start against a port whose combined value is zero. It then changes the port at a known falling edge and checks the stall cycle by cycle until the release. During the stall it also changes the accumulator input and drives other ports, so that a design that re-reads them live would release early or with the wrong data.

// File: rtl/evt_wait_pkg.sv
package evt_wait_pkg;
    typedef enum logic [1:0] {
        EW_RAW  = 2'b00,
        EW_MASK = 2'b01,
        EW_DIFF = 2'b10,
        EW_ALT  = 2'b11
    } ew_mode_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.stable;
endmodule

// File: rtl/evt_combine.sv
module evt_combine
    import evt_wait_pkg::*;
#(
    parameter int DW     = 4,
    parameter int NPORTS = 16,
    localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [NPORTS*DW-1:0] ports_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  ew_mode_e             mode_i,
    input  logic [DW-1:0]        acc_i,
    output logic [DW-1:0]        raw_o,
    output logic [DW-1:0]        comb_o,
    output logic                 hit_o
);
    logic [DW-1:0] slice [NPORTS];

    for (genvar g = 0; g < NPORTS; g++) begin : g_slice
        assign slice[g] = ports_i[g*DW +: DW];
    end

    always_comb begin
        raw_o = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (SEL_W'(i) == sel_i) raw_o = slice[i];
        end
        unique case (mode_i)
            EW_MASK: comb_o = raw_o & acc_i;
            EW_DIFF: comb_o = raw_o ^ acc_i;
            default: comb_o = raw_o;
        endcase
        hit_o = |comb_o;
    end
endmodule

// File: rtl/evt_wait_unit.sv
module evt_wait_unit
    import evt_wait_pkg::*;
#(
    parameter int DW     = 4,
    parameter int NPORTS = 16,
    localparam int SEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int PW    = NPORTS * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [PW-1:0]    port_i,
    input  logic [DW-1:0]    acc_i,
    output logic             stall_o,
    output logic             acc_we_o,
    output logic [DW-1:0]    acc_wdata_o,
    output logic             b_we_o,
    output logic [DW-1:0]    b_wdata_o,
    output logic             zf_clr_o
);
    typedef struct packed {
        logic             busy;
        ew_mode_e         mode;
        logic [SEL_W-1:0] sel;
        logic [DW-1:0]    acc;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [PW-1:0]    port_sync;
    logic             active;
    ew_mode_e         cur_mode;
    logic [SEL_W-1:0] cur_sel;
    logic [DW-1:0]    cur_acc;
    logic [DW-1:0]    raw_val, comb_val;
    logic             hit;

    evt_sync #(.W(PW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (port_i),
        .q_o   (port_sync)
    );

    evt_combine #(.DW(DW), .NPORTS(NPORTS)) u_comb (
        .ports_i (port_sync),
        .sel_i   (cur_sel),
        .mode_i  (cur_mode),
        .acc_i   (cur_acc),
        .raw_o   (raw_val),
        .comb_o  (comb_val),
        .hit_o   (hit)
    );

    always_comb begin
        active   = start_i || c_q.busy;
        cur_mode = c_q.busy ? c_q.mode : ew_mode_e'(mode_i);
        cur_sel  = c_q.busy ? c_q.sel  : sel_i;
        cur_acc  = c_q.busy ? c_q.acc  : acc_i;

        c_d      = c_q;
        c_d.busy = active && !hit;
        if (!c_q.busy && start_i) begin
            c_d.mode = ew_mode_e'(mode_i);
            c_d.sel  = sel_i;
            c_d.acc  = acc_i;
        end

        stall_o     = active && !hit;
        acc_we_o    = active && hit;
        b_we_o      = active && hit;
        zf_clr_o    = active && hit;
        acc_wdata_o = comb_val;
        b_wdata_o   = raw_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    // R2
    stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_o && (acc_we_o || b_we_o)));

    // R2
    stall_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !start_i) |-> $past(stall_o));

    // R7
    release_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall_o) |-> (acc_we_o && b_we_o && zf_clr_o));

    // R7
    release_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we_o |-> (acc_wdata_o != '0));
endmodule

// File: tb/test_evt_wait_unit.sv
module test_evt_wait_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [3:0]  sel_i = '0;
    logic [63:0] port_i = '0;
    logic [3:0]  acc_i = '0;
    logic        stall_o, acc_we_o, b_we_o, zf_clr_o;
    logic [3:0]  acc_wdata_o, b_wdata_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    evt_wait_unit i_evt_wait_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .sel_i(sel_i), .port_i(port_i), .acc_i(acc_i), .stall_o(stall_o),
        .acc_we_o(acc_we_o), .acc_wdata_o(acc_wdata_o), .b_we_o(b_we_o),
        .b_wdata_o(b_wdata_o), .zf_clr_o(zf_clr_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_port(input int idx, input logic [3:0] v);
        port_i[idx*4 +: 4] = v;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_idle(input string req);
        check({req, " stall"}, {7'd0, stall_o}, 8'd0);
        check({req, " acc_we"}, {7'd0, acc_we_o}, 8'd0);
        check({req, " b_we"}, {7'd0, b_we_o}, 8'd0);
        check({req, " zf_clr"}, {7'd0, zf_clr_o}, 8'd0);
    endtask

    task automatic expect_release(input string req, input logic [3:0] a, input logic [3:0] b);
        check({req, " stall"}, {7'd0, stall_o}, 8'd0);
        check({req, " acc_we"}, {7'd0, acc_we_o}, 8'd1);
        check({req, " b_we"}, {7'd0, b_we_o}, 8'd1);
        check({req, " zf_clr"}, {7'd0, zf_clr_o}, 8'd1);
        check({req, " acc_wdata"}, {4'd0, acc_wdata_o}, {4'd0, a});
        check({req, " b_wdata"}, {4'd0, b_wdata_o}, {4'd0, b});
    endtask

    task automatic issue(input logic [1:0] m, input logic [3:0] s, input logic [3:0] a);
        @(negedge clk);
        start_i = 1'b1; mode_i = m; sel_i = s; acc_i = a;
        #1;
    endtask

    task automatic end_start();
        @(negedge clk);
        start_i = 1'b0; mode_i = 2'b00; sel_i = 4'hF; acc_i = 4'hF;
        #1;
    endtask

    task automatic t_reset();
        expect_idle("R1 during reset");
        tick(2);
        rst_n = 1'b1;
        tick(3);
        expect_idle("R1 after reset");
    endtask

    task automatic t_immediate_raw();
        set_port(5, 4'h6);
        tick(3);
        issue(2'b00, 4'd5, 4'h0);
        expect_release("R3 R4 immediate raw", 4'h6, 4'h6);
        end_start();
        expect_idle("R7 one-cycle strobe");
    endtask

    task automatic t_wait_raw();
        set_port(3, 4'h0);
        tick(3);
        issue(2'b00, 4'd3, 4'h0);
        check("R2 stall at start", {7'd0, stall_o}, 8'd1);
        check("R2 no write at start", {7'd0, acc_we_o}, 8'd0);
        end_start();
        set_port(3, 4'h9);
        #1;
        check("R9 stall after change", {7'd0, stall_o}, 8'd1);
        tick(1);
        check("R9 stall after one edge", {7'd0, stall_o}, 8'd1);
        check("R2 no b write while stalled", {7'd0, b_we_o}, 8'd0);
        tick(1);
        expect_release("R9 R4 release raw", 4'h9, 4'h9);
        tick(1);
        expect_idle("R7 after raw release");
        set_port(3, 4'h0);
    endtask

    task automatic t_masked();
        set_port(2, 4'b1100);
        tick(3);
        issue(2'b01, 4'd2, 4'b0011);
        check("R5 masked stall", {7'd0, stall_o}, 8'd1);
        end_start();
        acc_i = 4'b1111;
        set_port(2, 4'b1000);
        tick(4);
        check("R5 acc change ignored", {7'd0, stall_o}, 8'd1);
        set_port(2, 4'b1010);
        tick(2);
        expect_release("R5 masked release", 4'b0010, 4'b1010);
        tick(1);
        expect_idle("R7 after masked");
    endtask

    task automatic t_change();
        set_port(9, 4'b0101);
        tick(3);
        issue(2'b10, 4'd9, 4'b0101);
        check("R6 change stall", {7'd0, stall_o}, 8'd1);
        end_start();
        tick(3);
        check("R6 still stalled", {7'd0, stall_o}, 8'd1);
        set_port(9, 4'b0100);
        tick(2);
        expect_release("R6 falling bit release", 4'b0001, 4'b0100);
        tick(1);
        issue(2'b10, 4'd9, 4'b0100);
        check("R6 rising bit stall", {7'd0, stall_o}, 8'd1);
        end_start();
        set_port(9, 4'b1100);
        tick(2);
        expect_release("R6 rising bit release", 4'b1000, 4'b1100);
        tick(1);
    endtask

    task automatic t_select();
        set_port(7, 4'h0);
        tick(3);
        issue(2'b00, 4'd7, 4'h0);
        end_start();
        set_port(2, 4'hF);
        set_port(8, 4'hF);
        set_port(6, 4'hF);
        tick(4);
        check("R8 other ports ignored", {7'd0, stall_o}, 8'd1);
        check("R8 no write", {7'd0, acc_we_o}, 8'd0);
        set_port(7, 4'h4);
        tick(2);
        expect_release("R8 selected port release", 4'h4, 4'h4);
        tick(1);
    endtask

    task automatic t_alt_mode();
        set_port(11, 4'h0);
        tick(3);
        issue(2'b11, 4'd11, 4'hF);
        check("R10 alt mode stalls on zero port", {7'd0, stall_o}, 8'd1);
        end_start();
        set_port(11, 4'h3);
        tick(2);
        expect_release("R10 alt mode raw value", 4'h3, 4'h3);
        tick(1);
    endtask

    initial begin
        t_reset();
        t_immediate_raw();
        t_wait_raw();
        t_masked();
        t_change();
        t_select();
        t_alt_mode();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule